// File: doc/BRIEF.md
# Interlocked PLL Multiplier Control Register

This block is an 8-bit software-visible control register for a clock multiplier. It holds a run bit that turns the PLL on, and a 3-bit code that chooses the multiplication factor. A single-cycle write strobe with a data byte updates it. The current contents can be read back at all times, and the run bit and the decoded factor go straight to the PLL.

Each field changes only when its own interlocks allow it. Every write needs two things: the protect key, which comes from a separate protect register, must be open, and the global clock-change lock must be clear. The multiplier code is frozen while the PLL runs. The PLL may be started only when the system clock is the main oscillator, running undivided, with its divider-select field in effect. A start request made without those conditions is dropped, and a sticky error flag records it. Reserved bits cannot be corrupted, because they always hold their fixed values. Invalid multiplier codes are rejected, and the previous code stays in place.

Top module: `pllc_reg`

## Requirements
- R1: After synchronous reset, rd_data is 8'h12, pll_on is 0, mult_factor is 4 and en_err is 0.
- R2: A write whose strobe arrives while prot_unlock is 0 leaves rd_data, pll_on, mult_factor and en_err unchanged.
- R3: A write whose strobe arrives while clk_chg_lock is 1 has no effect on any output, even when prot_unlock is 1.
- R4: The multiplier code sits in bits 2:0. Code 3'b001 gives mult_factor 2, 3'b010 gives 4, 3'b011 gives 6 and 3'b100 gives 8. An accepted write updates the outputs one clock later.
- R5: An accepted write that carries code 3'b000, 3'b101, 3'b110 or 3'b111 in bits 2:0 keeps the previous multiplier code.
- R6: The multiplier code can change only on a write accepted while pll_on is 0. While pll_on is 1, bits 2:0 of the written data are ignored.
- R7: Bit 7 set on an accepted write turns pll_on from 0 to 1 only if clk_src_sub is 0, clk_div_sel is 0 and div_sel_active is 1. Otherwise pll_on stays 0 and en_err becomes 1.
- R8: Once set, en_err stays 1 until reset.
- R9: An accepted write with bit 7 clear turns pll_on off, whatever the clock status inputs are.
- R10: rd_data reads the run bit on bit 7, 0 on bits 6:5, 1 on bit 4, 0 on bit 3 and the multiplier code on bits 2:0, whatever was written to bits 6:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| prot_unlock | input | 1 | Protect key open (1 = writes allowed) |
| clk_chg_lock | input | 1 | Global clock-change lock (1 = all writes blocked) |
| clk_src_sub | input | 1 | System clock taken from the sub oscillator (0 = main) |
| clk_div_sel | input | DIV_SEL_W | System clock divider setting (0 = undivided) |
| div_sel_active | input | 1 | Divider-select field is in effect |
| pll_on | output | 1 | PLL run enable |
| mult_factor | output | 4 | Decoded multiplication factor |
| en_err | output | 1 | Sticky flag: a start request was refused |
| rd_data | output | 8 | Register read-back value |

## Verification
The bench builds the block with its default parameters: a 2-bit divider setting and a reset multiplier code of 3'b010. With these values every code in the 3-bit multiplier field can be reached, valid and invalid alike, and so can every divider setting that blocks a start. Random writes mix the interlock inputs, so refused starts, frozen codes and blocked writes all occur many times. Directed sequences cover the reset image, the error flag that stays set, and turning the PLL off under a bad clock status.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int REG_W  = 8;
    localparam int MULT_W = 3;
    localparam int FACT_W = MULT_W + 1;

    typedef logic [MULT_W-1:0] mult_code_t;

    // Register image seen by software
    typedef struct packed {
        logic       run;
        logic [1:0] zero_hi;
        logic       one_fix;
        logic       unassigned;
        mult_code_t code;
    } pllc_image_t;

    localparam logic [1:0] ZERO_HI_VAL = 2'b00;
    localparam logic       ONE_FIX_VAL = 1'b1;
    localparam logic       UNASN_VAL   = 1'b0;

    function automatic logic code_ok(input mult_code_t c);
        return (c >= mult_code_t'(1)) && (c <= mult_code_t'(4));
    endfunction

    function automatic logic [FACT_W-1:0] code_to_factor(input mult_code_t c);
        return {c, 1'b0};
    endfunction

    function automatic pllc_image_t build_image(input logic run, input mult_code_t c);
        pllc_image_t img;
        img.run        = run;
        img.zero_hi    = ZERO_HI_VAL;
        img.one_fix    = ONE_FIX_VAL;
        img.unassigned = UNASN_VAL;
        img.code       = c;
        return img;
    endfunction

endpackage

// File: rtl/pllc_wr_gate.sv
module pllc_wr_gate (
    input  logic wr_en,
    input  logic prot_unlock,
    input  logic clk_chg_lock,
    output logic wr_accept
);
    always_comb begin
        wr_accept = wr_en & prot_unlock & ~clk_chg_lock;
    end
endmodule

// File: rtl/pllc_clk_precond.sv
module pllc_clk_precond #(
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk_src_sub,
    input  logic [DIV_SEL_W-1:0] clk_div_sel,
    input  logic                 div_sel_active,
    output logic                 start_ok
);
    always_comb begin
        start_ok = ~clk_src_sub & (clk_div_sel == '0) & div_sel_active;
    end
endmodule

// File: rtl/pllc_fields.sv
module pllc_fields
    import pllc_pkg::*;
#(
    parameter logic [MULT_W-1:0] RST_CODE = 3'b010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_accept,
    input  logic [REG_W-1:0] wr_data,
    input  logic             start_ok,
    output logic             run_q,
    output mult_code_t       code_q,
    output logic             err_q
);
    pllc_image_t req;

    always_comb begin
        req = pllc_image_t'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            code_q <= RST_CODE;
            err_q  <= 1'b0;
        end else if (wr_accept) begin
            if (!run_q && code_ok(req.code)) begin
                code_q <= req.code;
            end
            if (req.run) begin
                if (!run_q) begin
                    if (start_ok) begin
                        run_q <= 1'b1;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else begin
                run_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pllc_reg.sv
module pllc_reg
    import pllc_pkg::*;
#(
    parameter int                DIV_SEL_W = 2,
    parameter logic [MULT_W-1:0] RST_CODE  = 3'b010
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 prot_unlock,
    input  logic                 clk_chg_lock,
    input  logic                 clk_src_sub,
    input  logic [DIV_SEL_W-1:0] clk_div_sel,
    input  logic                 div_sel_active,
    output logic                 pll_on,
    output logic [FACT_W-1:0]    mult_factor,
    output logic                 en_err,
    output logic [REG_W-1:0]     rd_data
);
    logic       wr_accept;
    logic       start_ok;
    logic       run_q;
    mult_code_t code_q;
    logic       err_q;

    pllc_wr_gate u_gate (
        .wr_en        (wr_en),
        .prot_unlock  (prot_unlock),
        .clk_chg_lock (clk_chg_lock),
        .wr_accept    (wr_accept)
    );

    pllc_clk_precond #(.DIV_SEL_W(DIV_SEL_W)) u_pre (
        .clk_src_sub    (clk_src_sub),
        .clk_div_sel    (clk_div_sel),
        .div_sel_active (div_sel_active),
        .start_ok       (start_ok)
    );

    pllc_fields #(.RST_CODE(RST_CODE)) u_fields (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .wr_data   (wr_data),
        .start_ok  (start_ok),
        .run_q     (run_q),
        .code_q    (code_q),
        .err_q     (err_q)
    );

    always_comb begin
        pll_on      = run_q;
        mult_factor = code_to_factor(code_q);
        en_err      = err_q;
        rd_data     = REG_W'(build_image(run_q, code_q));
    end
endmodule

// File: rtl/pllc_reg_chk.sv
module pllc_reg_chk
    import pllc_pkg::*;
#(
    parameter int DIV_SEL_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic                 prot_unlock,
    input logic                 clk_chg_lock,
    input logic                 clk_src_sub,
    input logic [DIV_SEL_W-1:0] clk_div_sel,
    input logic                 div_sel_active,
    input logic                 pll_on,
    input logic [FACT_W-1:0]    mult_factor,
    input logic                 en_err,
    input logic [REG_W-1:0]     rd_data
);
    // R2
    locked_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !prot_unlock) |=> ($stable(rd_data) && $stable(en_err)));

    // R3
    chg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && clk_chg_lock) |=> ($stable(rd_data) && $stable(en_err)));

    // R5
    valid_code_chk: assert property (@(posedge clk) disable iff (rst)
        code_ok(rd_data[MULT_W-1:0]));

    // R6
    frozen_code_chk: assert property (@(posedge clk) disable iff (rst)
        pll_on |=> $stable(mult_factor));

    // R7
    start_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_on) |-> ($past(!clk_src_sub) && $past(clk_div_sel == '0) && $past(div_sel_active)));

    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        en_err |=> en_err);

    // R10
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:3] == 4'b0010);
endmodule

bind pllc_reg pllc_reg_chk #(.DIV_SEL_W(DIV_SEL_W)) u_chk (.*);

// File: tb/tb_pllc_reg.sv
module tb_pllc_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       prot_unlock;
    logic       clk_chg_lock;
    logic       clk_src_sub;
    logic [1:0] clk_div_sel;
    logic       div_sel_active;
    logic       pll_on;
    logic [3:0] mult_factor;
    logic       en_err;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    logic       m_run;
    logic [2:0] m_code;
    logic       m_err;

    always #2 clk = ~clk;

    pllc_reg dut (.*);

    function automatic logic [3:0] exp_factor(input logic [2:0] c);
        case (c)
            3'b001:  return 4'd2;
            3'b010:  return 4'd4;
            3'b011:  return 4'd6;
            3'b100:  return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic r, input logic [2:0] c);
        return {r, 2'b00, 1'b1, 1'b0, c};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " rd_data R10"}, rd_data, exp_rd(m_run, m_code));
        check({tag, " mult_factor R4"}, {4'b0, mult_factor}, {4'b0, exp_factor(m_code)});
        check({tag, " pll_on"}, {7'b0, pll_on}, {7'b0, m_run});
        check({tag, " en_err R8"}, {7'b0, en_err}, {7'b0, m_err});
    endtask

    task automatic model_write(input logic [7:0] d, input logic pk, input logic lk,
                               input logic sub, input logic [1:0] dv, input logic act);
        logic ok;
        if (pk && !lk) begin
            ok = !sub && dv == 2'b00 && act;
            if (!m_run && exp_factor(d[2:0]) != 4'd0) m_code = d[2:0];
            if (d[7]) begin
                if (!m_run) begin
                    if (ok) m_run = 1'b1;
                    else    m_err = 1'b1;
                end
            end else begin
                m_run = 1'b0;
            end
        end
    endtask

    task automatic do_write(input string tag, input logic [7:0] d, input logic pk, input logic lk,
                            input logic sub, input logic [1:0] dv, input logic act);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; prot_unlock = pk; clk_chg_lock = lk;
        clk_src_sub = sub; clk_div_sel = dv; div_sel_active = act;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(d, pk, lk, sub, dv, act);
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_run = 1'b0; m_code = 3'b010; m_err = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; prot_unlock = 1'b0; clk_chg_lock = 1'b0;
        clk_src_sub = 1'b0; clk_div_sel = 2'b00; div_sel_active = 1'b1;
        do_reset();
        // R1 reset image
        check("R1 reset rd_data", rd_data, 8'h12);
        check("R1 reset factor", {4'b0, mult_factor}, 8'd4);
        check("R1 reset pll_on/en_err", {6'b0, pll_on, en_err}, 8'd0);

        // R2 protect key closed
        do_write("R2 key closed", 8'h01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
        check("R2 code kept", {5'b0, rd_data[2:0]}, 8'h02);
        // R3 lock blocks even start
        do_write("R3 lock", 8'h83, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
        check("R3 no start", {7'b0, pll_on}, 8'h00);
        // R4 each valid code, R10 reserved bits forced
        do_write("R4 x2", 8'h79, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        check("R4 factor 2 R10 rd", rd_data, 8'h11);
        do_write("R4 x6", 8'h03, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        do_write("R4 x8", 8'h04, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        // R5 invalid codes
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c > 4) begin
                do_write("R5 invalid code", 8'(c), 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
                check("R5 code kept x8", {4'b0, mult_factor}, 8'd8);
            end
        end
        // R7 refused start sets error
        do_write("R7 sub clk", 8'h82, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1);
        check("R7 refused", {6'b0, pll_on, en_err}, 8'b01);
        // R8 error stays through good start
        do_write("R7 good start", 8'h82, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        check("R8 sticky with run", {6'b0, pll_on, en_err}, 8'b11);
        // R6 code frozen while running
        do_write("R6 frozen", 8'h81, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        check("R6 still x4", {4'b0, mult_factor}, 8'd4);
        // R9 stop under bad clock status
        do_write("R9 stop", 8'h01, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0);
        check("R9 stopped", {7'b0, pll_on}, 8'h00);
        check("R9 code frozen on stop write", {5'b0, rd_data[2:0]}, 8'h02);
        do_reset();
        check("R8 cleared by reset", {7'b0, en_err}, 8'h00);
        do_write("R7 divided", 8'h81, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1);
        check("R7 divided refused", {6'b0, pll_on, en_err}, 8'b01);
        do_write("R7 field off", 8'h81, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        check("R7 field off refused", {7'b0, pll_on}, 8'h00);

        // random mix R2 R3 R5 R6 R7 R9
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (($urandom % 3) == 0) d[2:0] = 3'(1 + ($urandom % 4));
            do_write("random R2 R3 R5 R6 R7 R9", d,
                     ($urandom % 4) != 0, ($urandom % 5) == 0,
                     ($urandom % 4) == 0, 2'(($urandom % 3) == 0 ? $urandom : 0),
                     ($urandom % 5) != 0);
            if (($urandom % 50) == 0) do_reset();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule